// File: doc/BRIEF.md
# Serial Register Slave with Active-High Chip Enable

This block is the serial front end of a small register and RAM device. A host selects it by raising the chip-enable pin and then clocks in one command byte followed by any number of data bytes, most significant bit first. The command byte carries the transfer direction and a start address. Each data byte of a write is handed to the register file as a one-cycle write strobe. Each data byte of a read is fetched from the register file and shifted out on MISO. The address steps forward after every data byte and wraps inside a 64-location space.

All pins are sampled into the system clock domain, and serial clock edges are found there. The serial clock polarity is taken from the idle level of SCK when chip enable rises, so hosts with either idle polarity work without configuration. Both use clock phase 1. When chip enable is low, the serial logic is held cleared and the MISO driver is off. During a write the MISO driver is never enabled. During a read it turns on only when the first data bit is presented. The read strobe for a byte fires after the whole byte has gone out, so a register that clears when read loses nothing on an aborted transfer.

Top module: `spi_cehi_slave`

## Requirements
- R1: Bytes on MOSI are assembled most significant bit first. The first bit clocked in becomes bit 7 of the byte.
- R2: While chip enable is low, miso_oe is 0 and no strobe is issued. A partial byte is discarded and the next frame starts again at a command byte. After reset, miso_oe, wr_stb and rd_stb are 0 and reg_addr is 0.
- R3: In a read frame, miso_oe stays 0 for the whole command byte. During each data byte, MISO presents rd_data of the current address, bit 7 first, with miso_oe at 1.
- R4: In a write frame, miso_oe stays 0 from the start of the frame to its end.
- R5: When chip enable rises, the level of SCK is taken as the idle polarity for the frame, 0 or 1, and both polarities transfer identically.
- R6: MOSI is captured on the SCK edge that returns to the idle level. The next MISO bit is driven on the edge that leaves the idle level.
- R7: In the command byte, bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 5:0 give the start address, and bit 6 has no effect.
- R8: After each data byte the address increases by one, and it wraps from 63 to 0.
- R9: After the eighth bit of a write data byte, wr_stb is high for exactly one clock, with reg_addr and wr_data giving the byte's address and value.
- R10: After the eighth bit of a read data byte has been shifted out, rd_stb is high for exactly one clock, with reg_addr giving that byte's address. No rd_stb is issued for a read byte cut short by chip enable going low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pin | input | 1 | Chip enable, active high, asynchronous |
| sck_pin | input | 1 | Serial clock from host, asynchronous |
| mosi_pin | input | 1 | Serial data from host, asynchronous |
| miso_o | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | 6 | Register file address |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Write data, valid with wr_stb |
| rd_stb | output | 1 | One-cycle strobe after a read byte has gone out |
| rd_data | input | 8 | Register file data at reg_addr, combinational |

## Verification
The assertions assume that SCK is much slower than the system clock, with each SCK level lasting several clocks beyond the synchronizer depth. They also assume that SCK sits at its idle level when chip enable rises and that MOSI changes only on the leading edge. Under those conditions, strobes and loads never coincide with an SCK edge. The bench drives every level of SCK for eight system clocks. It holds SCK idle for several clocks around each chip-enable change and changes MOSI only together with the leading edge. A reference model of the register file and of the expected strobe order is compared against the outputs on every clock.

// File: rtl/spi_cehi_pkg.sv
package spi_cehi_pkg;
   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_t;
endpackage

// File: rtl/spi_cehi_sync.sv
module spi_cehi_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cehi_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_cehi_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_cehi_framer.sv
module spi_cehi_framer #(
   parameter int DATA_W    = 8,
   parameter int CPOL_MODE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_en,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              miso_o,
   output logic              miso_oe
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   if (CPOL_MODE < 0 || CPOL_MODE > 2) begin : g_bad_mode
      $error("spi_cehi_framer: CPOL_MODE must be 0, 1 or 2");
   end

   logic              ce_d;
   logic              sck_d;
   logic              cpol_w;
   logic              active;
   logic              edge_up;
   logic              edge_dn;
   logic              latch_e;
   logic              launch_e;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_d  <= 1'b0;
         sck_d <= 1'b0;
      end else begin
         ce_d  <= ce_s;
         sck_d <= sck_s;
      end
   end

   if (CPOL_MODE == 2) begin : g_cpol_auto
      logic cpol_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cpol_q <= 1'b0;
         else if (ce_s && !ce_d) cpol_q <= sck_s;
      end
      assign cpol_w = cpol_q;
   end else begin : g_cpol_fixed
      assign cpol_w = (CPOL_MODE == 1);
   end

   assign active   = ce_s && ce_d;
   assign edge_up  = sck_s && !sck_d;
   assign edge_dn  = !sck_s && sck_d;
   assign latch_e  = active && (cpol_w ? edge_up : edge_dn);
   assign launch_e = active && (cpol_w ? edge_dn : edge_up);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else if (!ce_s) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (latch_e) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh[DATA_W-2:0], mosi_s};
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         miso_o  <= 1'b0;
         miso_oe <= 1'b0;
      end else if (!ce_s) begin
         tx_sh   <= '0;
         miso_o  <= 1'b0;
         miso_oe <= 1'b0;
      end else if (tx_load) begin
         tx_sh <= tx_byte;
      end else if (launch_e && tx_en) begin
         miso_o  <= tx_sh[DATA_W-1];
         tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
         miso_oe <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_cehi_ctrl.sv
module spi_cehi_ctrl
   import spi_cehi_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_stb,
   output logic              tx_load,
   output logic              in_data,
   output logic              dir_wr
);
   localparam int DIR_POS = DATA_W - 1;

   if (ADDR_W > DATA_W - 2) begin : g_bad_addr
      $error("spi_cehi_ctrl: ADDR_W must leave the top two command bits free");
   end

   phase_t phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_CMD;
         dir_wr   <= 1'b0;
         reg_addr <= '0;
         wr_stb   <= 1'b0;
         wr_data  <= '0;
         rd_stb   <= 1'b0;
         tx_load  <= 1'b0;
      end else if (!ce_s) begin
         phase_q  <= PH_CMD;
         dir_wr   <= 1'b0;
         reg_addr <= '0;
         wr_stb   <= 1'b0;
         rd_stb   <= 1'b0;
         tx_load  <= 1'b0;
      end else begin
         wr_stb  <= 1'b0;
         rd_stb  <= 1'b0;
         tx_load <= rd_stb;
         if (wr_stb || rd_stb) reg_addr <= reg_addr + 1'b1;
         if (byte_done) begin
            if (phase_q == PH_CMD) begin
               dir_wr   <= rx_byte[DIR_POS];
               reg_addr <= rx_byte[ADDR_W-1:0];
               phase_q  <= PH_DATA;
               tx_load  <= !rx_byte[DIR_POS];
            end else if (dir_wr) begin
               wr_stb  <= 1'b1;
               wr_data <= rx_byte;
            end else begin
               rd_stb <= 1'b1;
            end
         end
      end
   end

   assign in_data = (phase_q == PH_DATA);
endmodule

// File: rtl/spi_cehi_slave.sv
module spi_cehi_slave #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CPOL_MODE   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_pin,
   input  logic              sck_pin,
   input  logic              mosi_pin,
   output logic              miso_o,
   output logic              miso_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_stb,
   input  logic [DATA_W-1:0] rd_data
);
   localparam int PIN_N = 3;

   if (DATA_W < 2) begin : g_bad_data
      $error("spi_cehi_slave: DATA_W must be at least 2");
   end

   logic [PIN_N-1:0]  pins_s;
   logic              ce_s;
   logic              sck_s;
   logic              mosi_s;
   logic              byte_done;
   logic [DATA_W-1:0] rx_byte;
   logic              tx_load;
   logic              in_data;
   logic              dir_wr;

   spi_cehi_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ce_pin, sck_pin, mosi_pin}),
      .d_sync  (pins_s)
   );

   assign {ce_s, sck_s, mosi_s} = pins_s;

   spi_cehi_framer #(.DATA_W(DATA_W), .CPOL_MODE(CPOL_MODE)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_s      (ce_s),
      .sck_s     (sck_s),
      .mosi_s    (mosi_s),
      .tx_load   (tx_load),
      .tx_byte   (rd_data),
      .tx_en     (in_data && !dir_wr),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso_o    (miso_o),
      .miso_oe   (miso_oe)
   );

   spi_cehi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_s      (ce_s),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .reg_addr  (reg_addr),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .rd_stb    (rd_stb),
      .tx_load   (tx_load),
      .in_data   (in_data),
      .dir_wr    (dir_wr)
   );
endmodule

// File: rtl/spi_cehi_chk.sv
module spi_cehi_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_s,
   input logic              in_data,
   input logic              dir_wr,
   input logic              miso_oe,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] reg_addr
);
   // R2
   ce_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> (!miso_oe && !wr_stb && !rd_stb));

   // R4
   write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_wr && ce_s) |=> !miso_oe);

   // R3
   oe_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> (in_data && !dir_wr));

   // R9
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R10
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb || rd_stb) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

   // R7
   one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_stb));
endmodule

bind spi_cehi_slave spi_cehi_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_s     (ce_s),
   .in_data  (in_data),
   .dir_wr   (dir_wr),
   .miso_oe  (miso_oe),
   .wr_stb   (wr_stb),
   .rd_stb   (rd_stb),
   .reg_addr (reg_addr)
);

// File: tb/spi_cehi_slave_test.sv
`timescale 1ns/1ps
module spi_cehi_slave_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_pin = 1'b0;
   logic       sck_pin = 1'b0;
   logic       mosi_pin = 1'b0;
   logic       miso_o;
   logic       miso_oe;
   logic [5:0] reg_addr;
   logic       wr_stb;
   logic [7:0] wr_data;
   logic       rd_stb;
   logic [7:0] rd_data;

   int  total = 0;
   int  bad = 0;
   bit  must_hiz = 1'b1;
   bit  done = 1'b0;
   logic [7:0] mem [64];
   int  exp_wr_q [$];
   int  exp_rd_q [$];
   logic [7:0] dq [$];

   always #4 clk = ~clk;

   assign rd_data = mem[reg_addr];

   spi_cehi_slave uut (
      .clk(clk), .rst_n(rst_n), .ce_pin(ce_pin), .sck_pin(sck_pin),
      .mosi_pin(mosi_pin), .miso_o(miso_o), .miso_oe(miso_oe),
      .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   // reference model: every clock, compare hi-Z rule and strobes against queues
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (must_hiz) chk(miso_oe == 1'b0, "R4 miso must be hi-Z", int'(miso_oe), 0);
         if (wr_stb) begin
            if (exp_wr_q.size() == 0) chk(1'b0, "R9 unexpected wr_stb", int'(reg_addr), -1);
            else begin
               int e;
               e = exp_wr_q.pop_front();
               chk({reg_addr, wr_data} == 14'(e), "R9 R1 wr addr/data",
                   int'({reg_addr, wr_data}), e);
               mem[reg_addr] = wr_data;
            end
         end
         if (rd_stb) begin
            if (exp_rd_q.size() == 0) chk(1'b0, "R10 unexpected rd_stb", int'(reg_addr), -1);
            else begin
               int e;
               e = exp_rd_q.pop_front();
               chk(int'(reg_addr) == e, "R10 rd_stb addr", int'(reg_addr), e);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic xfer(input logic cpol, input logic [7:0] b, input int nbits,
                       input bit sample, output logic [7:0] got);
      got = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         tick(1);
         sck_pin  = ~cpol;
         mosi_pin = b[i];
         tick(8);
         if (sample) begin
            chk(miso_oe == 1'b1, "R3 oe during read bit", int'(miso_oe), 1);
            got[i] = miso_o;
         end
         sck_pin = cpol;
         tick(8);
      end
   endtask

   task automatic start_frame(input logic cpol);
      sck_pin = cpol;
      tick(6);
      ce_pin = 1'b1;
      tick(8);
   endtask

   task automatic end_frame();
      tick(4);
      ce_pin = 1'b0;
      tick(6);
      must_hiz = 1'b1;
      tick(4);
      chk(exp_wr_q.size() == 0, "R9 missing wr_stb", exp_wr_q.size(), 0);
      chk(exp_rd_q.size() == 0, "R10 missing rd_stb", exp_rd_q.size(), 0);
   endtask

   task automatic do_write(input logic cpol, input logic [7:0] cmd);
      logic [7:0] junk;
      must_hiz = 1'b1;
      start_frame(cpol);
      xfer(cpol, cmd, 8, 1'b0, junk);
      foreach (dq[k]) begin
         exp_wr_q.push_back(int'({6'(int'(cmd[5:0]) + k), dq[k]}));
         xfer(cpol, dq[k], 8, 1'b0, junk);
      end
      end_frame();
   endtask

   task automatic do_read(input logic cpol, input logic [5:0] addr, input int n);
      logic [7:0] got;
      logic [7:0] exp;
      logic [5:0] a;
      must_hiz = 1'b1;
      start_frame(cpol);
      xfer(cpol, {2'b00, addr}, 8, 1'b0, got);
      must_hiz = 1'b0;
      for (int k = 0; k < n; k++) begin
         a   = 6'(int'(addr) + k);
         exp = mem[a];
         exp_rd_q.push_back(int'(a));
         xfer(cpol, 8'hFF, 8, 1'b1, got);
         chk(got == exp, "R3 R6 read byte MSB first", int'(got), int'(exp));
      end
      end_frame();
   endtask

   initial begin
      logic [7:0] junk;
      for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
      tick(5);
      rst_n = 1'b1;
      tick(3);
      // R2 reset state
      chk(miso_oe == 1'b0, "R2 reset miso_oe", int'(miso_oe), 0);
      chk(wr_stb == 1'b0 && rd_stb == 1'b0, "R2 reset strobes", int'({wr_stb, rd_stb}), 0);
      chk(reg_addr == 6'd0, "R2 reset addr", int'(reg_addr), 0);

      // R1 R7 R9: write, idle low, address 5
      dq = '{8'hA5, 8'h3C};
      do_write(1'b0, 8'h85);

      // R5 R7 R8: idle high, bit 6 set (ignored), wrap 62 -> 63 -> 0
      dq = '{8'h11, 8'h22, 8'h33};
      do_write(1'b1, 8'hFE);
      chk(mem[62] == 8'h11 && mem[0] == 8'h33, "R8 wrapped writes landed",
          int'(mem[0]), 8'h33);

      // R3 R6 R10: read back with idle low
      do_read(1'b0, 6'd5, 2);
      // R5 R8: read across the wrap with idle high
      do_read(1'b1, 6'd63, 2);

      // R2 R10: read aborted mid-byte gives no rd_stb and releases MISO
      must_hiz = 1'b1;
      start_frame(1'b0);
      xfer(1'b0, 8'h10, 8, 1'b0, junk);
      must_hiz = 1'b0;
      xfer(1'b0, 8'hFF, 4, 1'b0, junk);
      ce_pin = 1'b0;
      tick(6);
      chk(miso_oe == 1'b0, "R2 oe off after CE low", int'(miso_oe), 0);
      must_hiz = 1'b1;
      tick(10);
      chk(exp_rd_q.size() == 0, "R10 no strobe on abort", exp_rd_q.size(), 0);

      // R2: partial command discarded, next frame decodes a fresh command
      start_frame(1'b1);
      xfer(1'b1, 8'h00, 3, 1'b0, junk);
      ce_pin = 1'b0;
      tick(10);
      dq = '{8'h5A};
      do_write(1'b1, 8'hA0);
      do_read(1'b0, 6'd32, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule